// File: doc/BRIEF.md
# PCI Configuration Access Router

This block gives a host processor access to PCI configuration space through the usual two-port scheme. The host first writes a 32-bit configuration address into an address port. It then reads or writes a dword-wide data window. The block decodes the stored address and sends the access to one of several internal register files, which are the functions built into this chip on bus 0. Otherwise it issues a request on a downstream link and waits for that link's completion.

Host accesses are single-cycle strobes on dword-granular I/O addresses. Byte enables select the lanes. Lane k carries bits 8k+7:8k, which is the byte at I/O address base+k, so the lowest address holds the least significant byte.

Every access ends with a one-cycle acknowledge that carries the read data. The controller has three states:
- **IDLE** waits for a strobe. It moves to **RESPOND** for address-port, internal and ignored accesses, and to **FWD_WAIT** for forwarded ones.
- **FWD_WAIT** holds the downstream request. It moves to **RESPOND** when a completion arrives or when the timeout expires.
- **RESPOND** raises the acknowledge for one cycle and returns to **IDLE**.

Top module: `cfg_access_router`

## Requirements
- R1: A write to the address port (dword address 0x33E, byte address 0xCF8) with all four byte enables stores the address. Bit 31 is the enable, bits 23:16 the bus, 15:11 the device, 10:8 the function and 7:2 the register index. A full dword read returns the stored value with bits 1:0 as zero. After reset the value is zero.
- R2: With the enable set, bus 0, device d in 0..2 and function 0, a data-window access (dword address 0x33F) pulses only request bit d of the internal port. It presents register index bits 7:2, and the access is not forwarded.
- R3: With the enable set, bus 0 and device 3 to 31, the access is forwarded. The forward address equals the stored address.
- R4: With the enable set and a nonzero bus number, the access is forwarded whatever the device number.
- R5: Byte enables and write data pass unchanged to the internal port or the forward port. In read data, lanes whose enable is clear return zero, and enabled lanes return the selected register's bytes.
- R6: An address-port access with any byte enable clear leaves the stored address unchanged. Such a read returns 0xFFFFFFFF.
- R7: With the enable bit clear, a data-window read returns 0xFFFFFFFF and a write reaches neither the internal nor the forward port.
- R8: A forwarded access holds its request until a completion arrives. An aborted completion returns 0xFFFFFFFF. With no completion within TIMEOUT_CYCLES cycles, the access ends with 0xFFFFFFFF, and its acknowledge comes TIMEOUT_CYCLES+1 cycles after the strobe.
- R9: On bus 0, device 0 to 2 with a nonzero function number is not claimed. It is not forwarded, and reads return 0xFFFFFFFF.
- R10: Every access is acknowledged by exactly one one-cycle pulse. Address-port, internal and ignored accesses are acknowledged in the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_dw_addr | input | 14 | Host I/O dword address (byte address bits 15:2) |
| io_be | input | 4 | Host byte enables, lane k = byte address base+k |
| io_rd | input | 1 | Host read strobe, one cycle |
| io_wr | input | 1 | Host write strobe, one cycle |
| io_wdata | input | 32 | Host write data |
| io_rdata | output | 32 | Read data, valid with io_ack |
| io_ack | output | 1 | Access completion pulse |
| rf_req | output | NUM_LOCAL_DEV | Per-function internal register access strobe |
| rf_we | output | 1 | Internal access is a write |
| rf_reg | output | 6 | Internal register dword index |
| rf_be | output | 4 | Internal byte enables |
| rf_wdata | output | 32 | Internal write data |
| rf_rdata | input | NUM_LOCAL_DEV*32 | Internal read data, function i at bits 32i+31:32i |
| fwd_req | output | 1 | Downstream configuration request, held until done |
| fwd_we | output | 1 | Forwarded access is a write |
| fwd_addr | output | 32 | Forwarded configuration address |
| fwd_be | output | 4 | Forwarded byte enables |
| fwd_wdata | output | 32 | Forwarded write data |
| fwd_cpl | input | 1 | Downstream completion |
| fwd_abort | input | 1 | Completion ended in master abort |
| fwd_rdata | input | 32 | Downstream read data |

## Verification
The routing decision is tried with addresses that differ in one field at a time. Devices 0, 1 and 2 on bus 0 show that each internal function gets its own strobe. Devices 3 and 31 on bus 0 mark the claim boundary. Nonzero buses carrying a low device number prove that the bus overrides the device. A nonzero function and a clear enable bit each separate an unclaimed access from a claimed one. Byte-enable patterns of one byte, an upper word, a middle pair and a full dword reveal lane shifts or missed masking. Aborted, timed-out and narrow address-port accesses check the all-ones paths.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FWD_WAIT,
        ST_RESPOND
    } state_t;

    typedef enum logic [2:0] {
        RT_ADDR_WR,
        RT_ADDR_RD,
        RT_LOCAL,
        RT_FORWARD,
        RT_ALL_ONES
    } route_t;

    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        logic [31:0] m;
        for (int k = 0; k < 4; k++) begin
            m[8*k +: 8] = {8{be[k]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/cfgr_addr_reg.sv
module cfgr_addr_reg (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:2] wdata,
    output logic [31:0] q
);
    logic [31:2] q_hi;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_hi <= '0;
        end else if (wr_en) begin
            q_hi <= wdata;
        end
    end

    assign q = {q_hi, 2'b00};
endmodule

// File: rtl/cfgr_decode.sv
module cfgr_decode
    import cfgr_pkg::*;
#(
    parameter int          NUM_LOCAL_DEV = 3,
    parameter logic [13:0] ADDR_PORT     = 14'h33E,
    parameter logic [13:0] DATA_PORT     = 14'h33F
) (
    input  logic [13:0]              dw_addr,
    input  logic [3:0]               be,
    input  logic                     wr,
    input  logic                     cfg_en,
    input  logic [7:0]               cfg_bus,
    input  logic [4:0]               cfg_dev,
    input  logic [2:0]               cfg_func,
    output route_t                   route,
    output logic [NUM_LOCAL_DEV-1:0] local_hit
);
    logic [NUM_LOCAL_DEV-1:0] dev_match;

    for (genvar i = 0; i < NUM_LOCAL_DEV; i++) begin : g_dev
        assign dev_match[i] = (cfg_dev == 5'(i));
    end

    always_comb begin
        route     = RT_ALL_ONES;
        local_hit = '0;
        if (dw_addr == ADDR_PORT) begin
            if (be == 4'hF) begin
                route = wr ? RT_ADDR_WR : RT_ADDR_RD;
            end
        end else if (dw_addr == DATA_PORT && cfg_en && be != 4'h0) begin
            if (cfg_bus != 8'h00) begin
                route = RT_FORWARD;
            end else if (|dev_match) begin
                if (cfg_func == 3'd0) begin
                    route     = RT_LOCAL;
                    local_hit = dev_match;
                end
            end else begin
                route = RT_FORWARD;
            end
        end
    end
endmodule

// File: rtl/cfg_access_router.sv
module cfg_access_router
    import cfgr_pkg::*;
#(
    parameter int NUM_LOCAL_DEV  = 3,
    parameter int TIMEOUT_CYCLES = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [13:0]                 io_dw_addr,
    input  logic [3:0]                  io_be,
    input  logic                        io_rd,
    input  logic                        io_wr,
    input  logic [31:0]                 io_wdata,
    output logic [31:0]                 io_rdata,
    output logic                        io_ack,
    output logic [NUM_LOCAL_DEV-1:0]    rf_req,
    output logic                        rf_we,
    output logic [5:0]                  rf_reg,
    output logic [3:0]                  rf_be,
    output logic [31:0]                 rf_wdata,
    input  logic [NUM_LOCAL_DEV*32-1:0] rf_rdata,
    output logic                        fwd_req,
    output logic                        fwd_we,
    output logic [31:0]                 fwd_addr,
    output logic [3:0]                  fwd_be,
    output logic [31:0]                 fwd_wdata,
    input  logic                        fwd_cpl,
    input  logic                        fwd_abort,
    input  logic [31:0]                 fwd_rdata
);
    localparam logic [13:0] ADDR_PORT = 14'h33E;
    localparam logic [13:0] DATA_PORT = 14'h33F;
    localparam int          TMO_W     = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TIMEOUT_CYCLES - 1);

    state_t                   state_q, state_d;
    logic [31:0]              rdata_q, rdata_d;
    logic [TMO_W-1:0]         cnt_q, cnt_d;
    logic                     fwd_we_q, fwd_we_d;
    logic [31:0]              fwd_addr_q, fwd_addr_d;
    logic [3:0]               fwd_be_q, fwd_be_d;
    logic [31:0]              fwd_wdata_q, fwd_wdata_d;

    logic [31:0]              cfg_addr;
    route_t                   route;
    logic [NUM_LOCAL_DEV-1:0] local_hit;
    logic                     accept;
    logic [31:0]              local_rd;

    assign accept = (state_q == ST_IDLE) && (io_rd || io_wr);

    cfgr_decode #(
        .NUM_LOCAL_DEV(NUM_LOCAL_DEV),
        .ADDR_PORT    (ADDR_PORT),
        .DATA_PORT    (DATA_PORT)
    ) u_decode (
        .dw_addr  (io_dw_addr),
        .be       (io_be),
        .wr       (io_wr),
        .cfg_en   (cfg_addr[31]),
        .cfg_bus  (cfg_addr[23:16]),
        .cfg_dev  (cfg_addr[15:11]),
        .cfg_func (cfg_addr[10:8]),
        .route    (route),
        .local_hit(local_hit)
    );

    cfgr_addr_reg u_addr (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(accept && route == RT_ADDR_WR),
        .wdata(io_wdata[31:2]),
        .q    (cfg_addr)
    );

    // internal register-file port, combinational in the strobe cycle
    assign rf_req   = (accept && route == RT_LOCAL) ? local_hit : '0;
    assign rf_we    = io_wr;
    assign rf_reg   = cfg_addr[7:2];
    assign rf_be    = io_be;
    assign rf_wdata = io_wdata;

    always_comb begin
        local_rd = '0;
        for (int i = 0; i < NUM_LOCAL_DEV; i++) begin
            if (local_hit[i]) begin
                local_rd = local_rd | rf_rdata[32*i +: 32];
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            rdata_q     <= '0;
            cnt_q       <= '0;
            fwd_we_q    <= 1'b0;
            fwd_addr_q  <= '0;
            fwd_be_q    <= '0;
            fwd_wdata_q <= '0;
        end else begin
            state_q     <= state_d;
            rdata_q     <= rdata_d;
            cnt_q       <= cnt_d;
            fwd_we_q    <= fwd_we_d;
            fwd_addr_q  <= fwd_addr_d;
            fwd_be_q    <= fwd_be_d;
            fwd_wdata_q <= fwd_wdata_d;
        end
    end

    // next state
    always_comb begin
        state_d     = state_q;
        rdata_d     = rdata_q;
        cnt_d       = cnt_q;
        fwd_we_d    = fwd_we_q;
        fwd_addr_d  = fwd_addr_q;
        fwd_be_d    = fwd_be_q;
        fwd_wdata_d = fwd_wdata_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_RESPOND;
                    unique case (route)
                        RT_ADDR_WR:  rdata_d = '0;
                        RT_ADDR_RD:  rdata_d = cfg_addr;
                        RT_LOCAL:    rdata_d = io_wr ? '0 : (local_rd & lane_mask(io_be));
                        RT_ALL_ONES: rdata_d = '1;
                        RT_FORWARD: begin
                            state_d     = ST_FWD_WAIT;
                            cnt_d       = '0;
                            fwd_we_d    = io_wr;
                            fwd_addr_d  = cfg_addr;
                            fwd_be_d    = io_be;
                            fwd_wdata_d = io_wdata;
                        end
                        default:     rdata_d = '1;
                    endcase
                end
            end
            ST_FWD_WAIT: begin
                if (fwd_cpl) begin
                    state_d = ST_RESPOND;
                    if (fwd_abort) begin
                        rdata_d = '1;
                    end else begin
                        rdata_d = fwd_we_q ? '0 : (fwd_rdata & lane_mask(fwd_be_q));
                    end
                end else if (cnt_q == TMO_LAST) begin
                    state_d = ST_RESPOND;
                    rdata_d = '1;
                end else begin
                    cnt_d = cnt_q + TMO_W'(1);
                end
            end
            ST_RESPOND: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        io_ack    = (state_q == ST_RESPOND);
        io_rdata  = rdata_q;
        fwd_req   = (state_q == ST_FWD_WAIT);
        fwd_we    = fwd_we_q;
        fwd_addr  = fwd_addr_q;
        fwd_be    = fwd_be_q;
        fwd_wdata = fwd_wdata_q;
    end

    AST_LOCAL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rf_req)); // R2

    AST_LOCAL_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_req != '0) |-> cfg_addr[31]); // R7

    AST_ADDR_DWORD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_addr) |-> $past(io_wr && io_be == 4'hF && io_dw_addr == ADDR_PORT)); // R6

    AST_FWD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_req && !fwd_cpl && cnt_q != TMO_LAST) |=> (fwd_req && $stable(fwd_addr))); // R8

    AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < TMO_W'(TIMEOUT_CYCLES)); // R8

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        io_ack |=> !io_ack); // R10

endmodule

// File: tb/tb_cfg_access_router.sv
module tb_cfg_access_router;
    localparam int NDEV = 3;
    localparam int TMO  = 16;
    localparam logic [13:0] AP = 14'h33E;
    localparam logic [13:0] DP = 14'h33F;
    localparam logic [31:0] FWD_DATA = 32'hCAFE_F00D;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [13:0] io_dw_addr = '0;
    logic [3:0]  io_be = '0;
    logic        io_rd = 1'b0, io_wr = 1'b0;
    logic [31:0] io_wdata = '0, io_rdata;
    logic        io_ack;
    logic [NDEV-1:0] rf_req;
    logic        rf_we;
    logic [5:0]  rf_reg;
    logic [3:0]  rf_be;
    logic [31:0] rf_wdata;
    logic [NDEV*32-1:0] rf_rdata;
    logic        fwd_req, fwd_we;
    logic [31:0] fwd_addr, fwd_wdata;
    logic [3:0]  fwd_be;
    logic        fwd_cpl = 1'b0, fwd_abort = 1'b0;
    logic [31:0] fwd_rdata = FWD_DATA;

    int n_chk = 0, n_fail = 0;
    int fwd_mode = 0;
    int wait_cnt = 0;

    logic [NDEV-1:0] s_rf;
    logic [5:0]  s_rf_reg;
    logic [3:0]  s_rf_be;
    logic        s_rf_we;
    logic [31:0] s_rf_wd;
    logic        s_fwd, s_fwd_we;
    logic [31:0] s_fwd_addr;
    logic [3:0]  s_fwd_be;

    always #10 clk = ~clk;

    function automatic logic [31:0] local_val(input int d);
        return 32'h1020_3040 + d * 32'h0101_0101;
    endfunction

    function automatic logic [31:0] bmask(input logic [3:0] be);
        logic [31:0] m = '0;
        for (int k = 0; k < 4; k++) if (be[k]) m[8*k +: 8] = 8'hFF;
        return m;
    endfunction

    assign rf_rdata = {local_val(2), local_val(1), local_val(0)};

    cfg_access_router #(.NUM_LOCAL_DEV(NDEV), .TIMEOUT_CYCLES(TMO)) dut (
        .clk(clk), .rst_n(rst_n),
        .io_dw_addr(io_dw_addr), .io_be(io_be), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ack(io_ack),
        .rf_req(rf_req), .rf_we(rf_we), .rf_reg(rf_reg), .rf_be(rf_be),
        .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
        .fwd_req(fwd_req), .fwd_we(fwd_we), .fwd_addr(fwd_addr), .fwd_be(fwd_be),
        .fwd_wdata(fwd_wdata), .fwd_cpl(fwd_cpl), .fwd_abort(fwd_abort),
        .fwd_rdata(fwd_rdata)
    );

    // downstream responder: mode 0 completes, 1 aborts, 2 never answers
    initial begin
        forever begin
            @(negedge clk);
            if (fwd_cpl) begin
                fwd_cpl = 1'b0; fwd_abort = 1'b0; wait_cnt = 0;
            end else if (fwd_req) begin
                wait_cnt++;
                if (wait_cnt >= 2 && fwd_mode != 2) begin
                    fwd_cpl = 1'b1; fwd_abort = (fwd_mode == 1);
                end
            end else begin
                wait_cnt = 0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [13:0] a, input logic [3:0] be,
                          input logic [31:0] wd, output logic [31:0] rd, output int lat);
        @(negedge clk);
        io_dw_addr = a; io_be = be; io_wdata = wd; io_wr = wr; io_rd = !wr;
        #1;
        s_rf = rf_req; s_rf_reg = rf_reg; s_rf_be = rf_be; s_rf_we = rf_we; s_rf_wd = rf_wdata;
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0;
        lat = 1; s_fwd = 1'b0;
        while (!io_ack && lat < 1000) begin
            if (fwd_req) begin
                s_fwd = 1'b1; s_fwd_addr = fwd_addr; s_fwd_be = fwd_be; s_fwd_we = fwd_we;
            end
            @(negedge clk);
            lat++;
        end
        rd = io_rdata;
    endtask

    // {config address, byte enables, kind}: kind 0..2 internal, 4 forward, 7 all ones
    localparam logic [39:0] VEC [9] = '{
        {32'h8000_0010, 4'hF, 4'd0},
        {32'h8000_0824, 4'h1, 4'd1},
        {32'h8000_1008, 4'hC, 4'd2},
        {32'h8000_1804, 4'hF, 4'd4},
        {32'h8000_F8FC, 4'h2, 4'd4},
        {32'h8001_0000, 4'hF, 4'd4},
        {32'h80FF_1000, 4'h6, 4'd4},
        {32'h8000_0100, 4'hF, 4'd7},
        {32'h0000_0010, 4'hF, 4'd7}
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int lat;
        repeat (3) @(negedge clk);
        chk("R10 reset ack", 32'(io_ack), 32'd0);
        chk("R8 reset fwd_req", 32'(fwd_req), 32'd0);
        rst_n = 1'b1;

        access(1'b0, AP, 4'hF, '0, rd, lat);
        chk("R1 reset address", rd, 32'h0);

        access(1'b1, AP, 4'hF, 32'h8012_3457, rd, lat);
        chk("R10 address write latency", 32'(lat), 32'd1);
        access(1'b0, AP, 4'hF, '0, rd, lat);
        chk("R1 address readback", rd, 32'h8012_3454);

        access(1'b1, AP, 4'h3, 32'h0000_0000, rd, lat);
        access(1'b0, AP, 4'hF, '0, rd, lat);
        chk("R6 narrow write ignored", rd, 32'h8012_3454);
        access(1'b0, AP, 4'h1, '0, rd, lat);
        chk("R6 narrow read", rd, 32'hFFFF_FFFF);

        for (int i = 0; i < 9; i++) begin
            logic [31:0] ca = VEC[i][39:8];
            logic [3:0]  be = VEC[i][7:4];
            int          kind = int'(VEC[i][3:0]);
            string       tag;
            logic [31:0] exp;
            if (kind < 3) tag = "R2";
            else if (kind == 7) tag = ca[31] ? "R9" : "R7";
            else tag = (ca[23:16] != 0) ? "R4" : "R3";
            access(1'b1, AP, 4'hF, ca, rd, lat);
            access(1'b0, DP, be, '0, rd, lat);
            if (kind < 3) exp = local_val(kind) & bmask(be);
            else if (kind == 4) exp = FWD_DATA & bmask(be);
            else exp = 32'hFFFF_FFFF;
            chk({tag, " R5 read data"}, rd, exp);
            chk({tag, " internal strobe"}, 32'(s_rf), (kind < 3) ? 32'(1 << kind) : 32'd0);
            chk({tag, " forwarded"}, 32'(s_fwd), (kind == 4) ? 32'd1 : 32'd0);
            if (kind < 3) chk({tag, " register index"}, 32'(s_rf_reg), 32'(ca[7:2]));
            if (kind == 4) chk({tag, " forward address"}, s_fwd_addr, ca);
            if (kind < 3) chk("R10 internal latency", 32'(lat), 32'd1);
        end

        access(1'b1, AP, 4'hF, 32'h8000_0828, rd, lat);
        access(1'b1, DP, 4'b0110, 32'hAABB_CCDD, rd, lat);
        chk("R5 write strobe", 32'(s_rf), 32'b010);
        chk("R5 write flag", 32'(s_rf_we), 32'd1);
        chk("R5 write lanes", 32'(s_rf_be), 32'b0110);
        chk("R5 write data", s_rf_wd, 32'hAABB_CCDD);

        access(1'b1, AP, 4'hF, 32'h0000_0828, rd, lat);
        access(1'b1, DP, 4'hF, 32'h1234_5678, rd, lat);
        chk("R7 disabled write internal", 32'(s_rf), 32'd0);
        chk("R7 disabled write forward", 32'(s_fwd), 32'd0);

        access(1'b1, AP, 4'hF, 32'h8000_2000, rd, lat);
        access(1'b1, DP, 4'h8, 32'h5500_0000, rd, lat);
        chk("R3 forwarded write flag", 32'(s_fwd_we), 32'd1);
        chk("R5 forwarded write lanes", 32'(s_fwd_be), 32'h8);

        fwd_mode = 1;
        access(1'b0, DP, 4'hF, '0, rd, lat);
        chk("R8 abort data", rd, 32'hFFFF_FFFF);
        chk("R8 abort forwarded", 32'(s_fwd), 32'd1);

        fwd_mode = 2;
        access(1'b0, DP, 4'hF, '0, rd, lat);
        chk("R8 timeout data", rd, 32'hFFFF_FFFF);
        chk("R8 timeout latency", 32'(lat), 32'(TMO + 1));
        fwd_mode = 0;

        access(1'b0, DP, 4'hF, '0, rd, lat);
        chk("R8 completion data after timeout", rd, FWD_DATA);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule